// File: doc/BRIEF.md
# Receive Message Queue Controller

This block takes fixed-size message packets from a network port and places them into a circular receive queue held in local memory. Each packet carries four data words. An accepted packet is copied word by word into its queue slot through a simple synchronous RAM write port. The sender then receives a one-cycle acknowledge. If every slot is taken, the packet is refused with a one-cycle negative acknowledge and nothing is written. A queue control word holds the tail slot, the slot limit and an occupancy threshold. When a store brings the occupancy up to the threshold, a sticky signal bit is set, and an interrupt is raised when it is enabled.

Software owns the head of the queue. After it has consumed messages it writes an advance amount, which moves the head forward and frees that many slots. If a head advance lands in the same cycle as the acceptance of a packet, or in the same cycle as the final word write of a packet, the packet side waits one cycle. This keeps the two occupancy updates in strict order.

The state machine has four states. `S_IDLE` waits for a packet. `S_STORE` writes the words. `S_ACK` and `S_NACK` each last one cycle and carry the response. The transitions are:
- `S_IDLE`→`S_STORE`: a packet is present, there is no head advance, and the queue is not full.
- `S_IDLE`→`S_NACK`: a packet is present, there is no head advance, and the queue is full.
- `S_IDLE`→`S_IDLE`: nothing is present, or a head advance stalls the packet.
- `S_STORE`→`S_STORE`: more words remain, or the last word is held by a head advance.
- `S_STORE`→`S_ACK`: the last word is written with no head advance in that cycle. This is the commit.
- `S_ACK`→`S_IDLE` and `S_NACK`→`S_IDLE`: always.

Top module: `rxq_ctrl`

## Requirements
- R1: After reset:
  - the slot limit and the threshold both equal SLOTS;
  - interrupt enable, the signal bit, head, tail and occupancy are all zero;
  - `net_ack`, `net_nack`, `mem_we` and `irq` are low.
- R2: Acceptance and storing of a packet:
  - A packet present on a clock edge while the queue is not full and no head advance is written is accepted.
  - Starting with the next cycle, its WORDS words are written on consecutive cycles.
  - Word k, taken from `net_payload` bits [k*DATA_W +: DATA_W], goes to address slot*WORDS+k, where slot is the tail.
  - `net_ack` pulses for one cycle in the cycle after the last word is written.
- R3: Occupancy rises by one for each stored packet and never exceeds the slot limit.
- R4: A packet that arrives while occupancy equals the limit is refused. `net_nack` pulses in the cycle after the acceptance edge. No memory write occurs, and tail and occupancy stay unchanged.
- R5: After each stored packet the tail advances by one, wrapping to 0 when it reaches the limit.
- R6: The signal bit and the interrupt:
  - A store that brings occupancy to at least a nonzero threshold sets the signal bit (control bit 25).
  - The bit stays set until a control write with bit 25 set to 1 clears it.
  - `irq` equals the signal bit ANDed with the enable (control bit 24).
  - A threshold of 0 never sets the bit.
- R7: Serialisation with head advances:
  - A head advance written in the cycle a packet would be accepted delays the acceptance by one cycle, so the acknowledge comes one cycle later.
  - A head advance during the last word cycle holds that word one more cycle before the commit.
- R8: A write to register 1 moves the head forward by bits [7:0] (modulo the limit) and lowers occupancy by the same amount. The amount is clipped to the present occupancy.
- R9: Register layout and the limit field:
  - Register 0 reads tail [7:0], limit [15:8], threshold [23:16], enable [24] and signal [25]. The tail field ignores writes.
  - Register 1 reads head [7:0] and occupancy [15:8].
  - A written limit of 0 becomes 1, and a written limit above SLOTS becomes SLOTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| net_valid | input | 1 | Packet present; held by the sender until it sees ack or nack |
| net_payload | input | WORDS*DATA_W | Packet words, word 0 in the low bits |
| net_ack | output | 1 | One-cycle positive acknowledge |
| net_nack | output | 1 | One-cycle negative acknowledge (queue full) |
| mem_we | output | 1 | RAM write strobe |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | DATA_W | RAM write data |
| sw_we | input | 1 | Register write strobe |
| sw_addr | input | 1 | Register select: 0 control, 1 head |
| sw_wdata | input | 26 | Register write data |
| sw_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Threshold interrupt |

## Verification
The sweep runs over every limit from 1 to 4. At each limit the queue is filled until one packet past the limit. This separates correct wrapping and full detection from off-by-one limits: the nack must appear exactly on the packet after the limit, with no memory write. Stored words are compared slot by slot and word by word against an arithmetic pattern, which exposes swapped word order or wrong slot addressing. A head advance issued in the same cycle as a send must add exactly one cycle to the acknowledge latency. An oversized advance must empty the queue without underflow. The threshold is set to half the limit, and the interrupt is enabled at some limits and not at others, so the sticky bit and its gating are seen apart.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_STORE = 2'd1,
        S_ACK   = 2'd2,
        S_NACK  = 2'd3
    } rxq_state_e;

    localparam int FIELD_W  = 8;
    localparam int REG_W    = 26;
    localparam int TAIL_LSB = 0;
    localparam int LIM_LSB  = 8;
    localparam int THR_LSB  = 16;
    localparam int IEN_BIT  = 24;
    localparam int SIG_BIT  = 25;
    localparam int HEAD_LSB = 0;
    localparam int OCC_LSB  = 8;
    localparam int ADV_LSB  = 0;
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_HEAD = 1'b1;
endpackage

// File: rtl/rxq_regs.sv
module rxq_regs
    import rxq_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             set_sig,
    output logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] thr,
    output logic             irq_en,
    output logic             sig
);
    logic [FIELD_W-1:0] lim_f;
    logic [FIELD_W-1:0] thr_f;
    logic [CNT_W-1:0]   lim_clamped;
    logic [CNT_W-1:0]   thr_clamped;
    logic               unused_tail_bits;

    assign lim_f = wdata[LIM_LSB +: FIELD_W];
    assign thr_f = wdata[THR_LSB +: FIELD_W];
    assign unused_tail_bits = ^wdata[TAIL_LSB +: FIELD_W];

    always_comb begin
        if (lim_f == '0)
            lim_clamped = CNT_W'(1);
        else if (lim_f > FIELD_W'(SLOTS))
            lim_clamped = CNT_W'(SLOTS);
        else
            lim_clamped = lim_f[CNT_W-1:0];
        if (thr_f > FIELD_W'(SLOTS))
            thr_clamped = CNT_W'(SLOTS);
        else
            thr_clamped = thr_f[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit  <= CNT_W'(SLOTS);
            thr    <= CNT_W'(SLOTS);
            irq_en <= 1'b0;
        end else if (ctrl_we) begin
            limit  <= lim_clamped;
            thr    <= thr_clamped;
            irq_en <= wdata[IEN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sig <= 1'b0;
        else if (set_sig)
            sig <= 1'b1;
        else if (ctrl_we && wdata[SIG_BIT])
            sig <= 1'b0;
    end
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs
    import rxq_pkg::*;
#(
    parameter int PTR_W = 3,
    parameter int CNT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic               adv_we,
    input  logic [FIELD_W-1:0] adv_amt,
    input  logic [CNT_W-1:0]   limit,
    output logic [PTR_W-1:0]   head,
    output logic [PTR_W-1:0]   tail,
    output logic [CNT_W-1:0]   count,
    output logic               full
);
    logic [CNT_W-1:0] adv_eff;
    logic [CNT_W:0]   head_sum;
    logic [CNT_W-1:0] tail_inc;
    logic [PTR_W-1:0] head_nx;
    logic [PTR_W-1:0] tail_nx;

    always_comb begin
        if (adv_amt > FIELD_W'(count))
            adv_eff = count;
        else
            adv_eff = adv_amt[CNT_W-1:0];
        head_sum = {1'b0, (CNT_W)'(head)} + {1'b0, adv_eff};
        if (head_sum >= {1'b0, limit})
            head_nx = PTR_W'(head_sum - {1'b0, limit});
        else
            head_nx = PTR_W'(head_sum);
        tail_inc = (CNT_W)'(tail) + CNT_W'(1);
        tail_nx  = (tail_inc >= limit) ? '0 : PTR_W'(tail_inc);
    end

    assign full = (count >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (commit) begin
            tail  <= tail_nx;
            count <= count + CNT_W'(1);
        end else if (adv_we) begin
            head  <= head_nx;
            count <= count - adv_eff;
        end
    end
endmodule

// File: rtl/rxq_fsm.sv
module rxq_fsm
    import rxq_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int WIDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              net_valid,
    input  logic              full,
    input  logic              hold,
    output logic [WIDX_W-1:0] widx,
    output logic              store_en,
    output logic              commit,
    output logic              ack,
    output logic              nack
);
    rxq_state_e state_q, state_d;
    logic       last;

    assign last = (widx == WIDX_W'(WORDS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (net_valid && !hold)
                    state_d = full ? S_NACK : S_STORE;
            end
            S_STORE: begin
                if (last && !hold)
                    state_d = S_ACK;
            end
            S_ACK:  state_d = S_IDLE;
            S_NACK: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        store_en = 1'b0;
        commit   = 1'b0;
        ack      = 1'b0;
        nack     = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_STORE: begin
                store_en = 1'b1;
                commit   = last && !hold;
            end
            S_ACK:  ack  = 1'b1;
            S_NACK: nack = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            widx <= '0;
        else if (state_q != S_STORE)
            widx <= '0;
        else if (!last)
            widx <= widx + WIDX_W'(1);
    end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SLOTS  = 8,
    parameter int WORDS  = 4,
    parameter int ADDR_W = $clog2(SLOTS * WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    net_valid,
    input  logic [WORDS*DATA_W-1:0] net_payload,
    output logic                    net_ack,
    output logic                    net_nack,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    sw_we,
    input  logic                    sw_addr,
    input  logic [REG_W-1:0]        sw_wdata,
    output logic [31:0]             sw_rdata,
    output logic                    irq
);
    localparam int PTR_W  = (SLOTS > 2) ? $clog2(SLOTS) : 1;
    localparam int CNT_W  = $clog2(SLOTS + 1);
    localparam int WIDX_W = (WORDS > 2) ? $clog2(WORDS) : 1;

    logic               ctrl_we;
    logic               head_wr;
    logic               commit;
    logic               store_en;
    logic               full;
    logic               set_sig;
    logic               sig_q;
    logic               ien_q;
    logic [CNT_W-1:0]   lim_val;
    logic [CNT_W-1:0]   thr_val;
    logic [CNT_W-1:0]   occ_cnt;
    logic [PTR_W-1:0]   head_ptr;
    logic [PTR_W-1:0]   tail_ptr;
    logic [WIDX_W-1:0]  widx;
    logic [CNT_W:0]     occ_after;

    assign ctrl_we = sw_we && (sw_addr == SEL_CTRL);
    assign head_wr = sw_we && (sw_addr == SEL_HEAD);

    rxq_fsm #(.WORDS(WORDS), .WIDX_W(WIDX_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .net_valid(net_valid),
        .full     (full),
        .hold     (head_wr),
        .widx     (widx),
        .store_en (store_en),
        .commit   (commit),
        .ack      (net_ack),
        .nack     (net_nack)
    );

    rxq_ptrs #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .adv_we (head_wr),
        .adv_amt(sw_wdata[ADV_LSB +: FIELD_W]),
        .limit  (lim_val),
        .head   (head_ptr),
        .tail   (tail_ptr),
        .count  (occ_cnt),
        .full   (full)
    );

    assign occ_after = {1'b0, occ_cnt} + (CNT_W+1)'(1);
    assign set_sig   = commit && (thr_val != '0) && (occ_after >= {1'b0, thr_val});

    rxq_regs #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_we(ctrl_we),
        .wdata  (sw_wdata),
        .set_sig(set_sig),
        .limit  (lim_val),
        .thr    (thr_val),
        .irq_en (ien_q),
        .sig    (sig_q)
    );

    assign mem_we    = store_en;
    assign mem_addr  = ADDR_W'(tail_ptr) * ADDR_W'(WORDS) + ADDR_W'(widx);
    assign mem_wdata = net_payload[widx*DATA_W +: DATA_W];
    assign irq       = sig_q & ien_q;

    always_comb begin
        sw_rdata = '0;
        if (sw_addr == SEL_CTRL) begin
            sw_rdata[TAIL_LSB +: FIELD_W] = FIELD_W'(tail_ptr);
            sw_rdata[LIM_LSB  +: FIELD_W] = FIELD_W'(lim_val);
            sw_rdata[THR_LSB  +: FIELD_W] = FIELD_W'(thr_val);
            sw_rdata[IEN_BIT]             = ien_q;
            sw_rdata[SIG_BIT]             = sig_q;
        end else begin
            sw_rdata[HEAD_LSB +: FIELD_W] = FIELD_W'(head_ptr);
            sw_rdata[OCC_LSB  +: FIELD_W] = FIELD_W'(occ_cnt);
        end
    end
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int CNT_W = 4,
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             net_ack,
    input logic             net_nack,
    input logic             mem_we,
    input logic             sw_we,
    input logic             sw_addr,
    input logic             clr_bit,
    input logic             irq,
    input logic             sig,
    input logic [CNT_W-1:0] occ,
    input logic [CNT_W-1:0] lim,
    input logic [PTR_W-1:0] tail
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= lim); // R3
    AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(net_ack && net_nack)); // R4
    AST_NACK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        net_nack |-> ($past(occ) == $past(lim))); // R4
    AST_NACK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        net_nack |-> !mem_we); // R4
    AST_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        net_ack |-> $past(mem_we)); // R2
    AST_TAIL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_W)'(tail) < lim); // R5
    AST_SIG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sig && !(sw_we && !sw_addr && clr_bit)) |=> sig); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> sig); // R6
    AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && sw_we && sw_addr) |=> mem_we); // R7
endmodule

bind rxq_ctrl rxq_chk #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .net_ack (net_ack),
    .net_nack(net_nack),
    .mem_we  (mem_we),
    .sw_we   (sw_we),
    .sw_addr (sw_addr),
    .clr_bit (sw_wdata[25]),
    .irq     (irq),
    .sig     (sig_q),
    .occ     (occ_cnt),
    .lim     (lim_val),
    .tail    (tail_ptr)
);

// File: tb/tb_rxq_ctrl.sv
module tb_rxq_ctrl;
    localparam int DATA_W = 32;
    localparam int SLOTS  = 8;
    localparam int WORDS  = 4;
    localparam int ADDR_W = $clog2(SLOTS * WORDS);

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    net_valid = 1'b0;
    logic [WORDS*DATA_W-1:0] net_payload = '0;
    logic                    net_ack, net_nack, mem_we, irq;
    logic [ADDR_W-1:0]       mem_addr;
    logic [DATA_W-1:0]       mem_wdata;
    logic                    sw_we = 1'b0;
    logic                    sw_addr = 1'b0;
    logic [25:0]             sw_wdata = '0;
    logic [31:0]             sw_rdata;

    int checks = 0;
    int failures = 0;
    int wr_cnt = 0;
    bit finished = 0;
    logic [DATA_W-1:0] bmem [SLOTS*WORDS];

    always #4 clk = ~clk;

    rxq_ctrl #(.DATA_W(DATA_W), .SLOTS(SLOTS), .WORDS(WORDS)) dut (
        .clk(clk), .rst_n(rst_n), .net_valid(net_valid), .net_payload(net_payload),
        .net_ack(net_ack), .net_nack(net_nack), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            bmem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic sw_write(input logic sel, input logic [25:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = sel; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0; sw_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        @(negedge clk);
        sw_addr = sel;
        #1 v = sw_rdata;
    endtask

    function automatic logic [25:0] ctrl_word(input int lim, input int thr, input bit ien, input bit clr);
        logic [25:0] w;
        w = '0;
        w[15:8] = 8'(lim);
        w[23:16] = 8'(thr);
        w[24] = ien;
        w[25] = clr;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pat(input int l, input int i, input int k);
        return 32'hA000_0000 | DATA_W'(l << 16) | DATA_W'(i << 4) | DATA_W'(k);
    endfunction

    task automatic send(input int l, input int i, input bit adv_with, input int adv,
                        output bit got_ack, output bit got_nack, output int lat);
        @(negedge clk);
        for (int k = 0; k < WORDS; k++) net_payload[k*DATA_W +: DATA_W] = pat(l, i, k);
        net_valid = 1'b1;
        if (adv_with) begin
            sw_we = 1'b1; sw_addr = 1'b1; sw_wdata = 26'(adv);
        end
        lat = 0; got_ack = 0; got_nack = 0;
        while (lat < 50 && !got_ack && !got_nack) begin
            @(negedge clk);
            lat++;
            if (lat == 1) begin sw_we = 1'b0; sw_wdata = '0; end
            got_ack = net_ack;
            got_nack = net_nack;
        end
        net_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit a, n;
        int lat, eh, et, ec, thr, adv, w0;
        bit es, ien;

        do_reset();
        // R1 reset values
        #1;
        check(!net_ack && !net_nack && !mem_we && !irq, "R1 outputs", 0, 0);
        rd(1'b0, v);
        check(v == {6'b0, 1'b0, 1'b0, 8'(SLOTS), 8'(SLOTS), 8'd0}, "R1 ctrl", int'(v), 0);
        rd(1'b1, v);
        check(v == 32'd0, "R1 head/occ", int'(v), 0);

        // R9 limit clamping and read-only tail
        sw_write(1'b0, ctrl_word(0, 3, 0, 0) | 26'hFF);
        rd(1'b0, v);
        check(v[15:8] == 8'd1, "R9 limit 0 clamps to 1", int'(v[15:8]), 1);
        check(v[7:0] == 8'd0, "R9 tail ignores write", int'(v[7:0]), 0);
        sw_write(1'b0, ctrl_word(200, 3, 0, 0));
        rd(1'b0, v);
        check(v[15:8] == 8'(SLOTS), "R9 limit clamps to SLOTS", int'(v[15:8]), SLOTS);

        for (int l = 1; l <= 4; l++) begin
            do_reset();
            thr = (l + 1) / 2;
            ien = (l != 2);
            sw_write(1'b0, ctrl_word(l, thr, ien, 1));
            eh = 0; et = 0; ec = 0; es = 0;
            for (int i = 0; i <= l; i++) begin
                w0 = wr_cnt;
                send(l, i, 0, 0, a, n, lat);
                if (ec < l) begin
                    check(a && lat == 5, "R2 ack latency", lat, 5);
                    for (int k = 0; k < WORDS; k++)
                        check(bmem[et*WORDS+k] == pat(l, i, k), "R2 stored word",
                              int'(bmem[et*WORDS+k]), int'(pat(l, i, k)));
                    et = (et + 1) % l;
                    ec++;
                    if (ec >= thr) es = 1;
                end else begin
                    check(n && lat == 1, "R4 nack when full", lat, 1);
                    check(wr_cnt == w0, "R4 no write on nack", wr_cnt - w0, 0);
                end
            end
            rd(1'b0, v);
            check(v[7:0] == 8'(et), "R5 tail wrap", int'(v[7:0]), et);
            check(v[25] == es, "R6 signal set at threshold", int'(v[25]), int'(es));
            check(irq == (es & ien), "R6 irq gated", int'(irq), int'(es & ien));
            rd(1'b1, v);
            check(v[15:8] == 8'(ec), "R3 occupancy at limit", int'(v[15:8]), ec);

            adv = (l > 1) ? 2 : 1;
            send(l, 9, 1, adv, a, n, lat);
            check(a && lat == 6, "R7 stall on head advance", lat, 6);
            check(bmem[et*WORDS+1] == pat(l, 9, 1), "R7 word after stall",
                  int'(bmem[et*WORDS+1]), int'(pat(l, 9, 1)));
            eh = adv % l;
            et = (et + 1) % l;
            ec = ec - adv + 1;
            rd(1'b1, v);
            check(v[7:0] == 8'(eh), "R8 head advanced", int'(v[7:0]), eh);
            check(v[15:8] == 8'(ec), "R8 occupancy after advance", int'(v[15:8]), ec);

            sw_write(1'b0, ctrl_word(l, thr, ien, 1));
            rd(1'b0, v);
            check(v[25] == 1'b0 && irq == 1'b0, "R6 clear", int'(v[25]), 0);

            sw_write(1'b1, 26'd200);
            rd(1'b1, v);
            check(v[15:8] == 8'd0, "R8 clipped advance empties", int'(v[15:8]), 0);
            check(v[7:0] == 8'(et), "R8 head meets tail", int'(v[7:0]), et);

            send(l, 12, 0, 0, a, n, lat);
            check(a && lat == 5, "R2 store after empty", lat, 5);
            check(bmem[et*WORDS+3] == pat(l, 12, 3), "R2 last word slot",
                  int'(bmem[et*WORDS+3]), int'(pat(l, 12, 3)));
            rd(1'b0, v);
            check(v[25] == (thr <= 1), "R6 signal after one store", int'(v[25]), int'(thr <= 1));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule